// File: doc/BRIEF.md
# Per-Voice Multi-Stage Volume Envelope

This block produces the 16-bit volume envelope of a single synthesizer voice. It walks through delay, attack, hold, decay, sustain and release, moving one step per sample period on a `tick` strobe. A host programs it through three 16-bit write strobes that share one data bus. One holds a start/state word that encodes an optional pre-attack delay. One holds the attack rate and a hold duration. One holds the decay rate, a sustain level, a freeze flag and a phase bit. Writing the last of these starts a note or releases it.

The envelope value on `env_out` drives a volume multiplier downstream. `stage_out` shows which stage is active, so the surrounding voice logic can tell when a voice has gone silent and may be reused. Delay and hold are counted in coarse time units. Each unit is a fixed number of ticks, set by parameters.

Top module: `voice_env_gen`

## Requirements
- R1: After a synchronous active-low reset, `env_out` is 0 and `stage_out` is 0. Stage codes: 0 idle, 1 delay, 2 attack, 3 hold, 4 decay, 5 sustain, 6 release.
- R2: The state word is written with `wr_state`. If its bit 15 is clear and it holds 0x8000−n, an attack request enters delay with `env_out` = 0. Delay lasts n×DLY_DIV ticks and then gives way to attack. If bit 15 is set, attack starts at once.
- R3: In attack, each tick adds the rise step of the attack code (bits 6:0 of the `wr_ha` word). The rise step is 0 for code 0. For any other code c it is ((16 + c mod 16) × 2^(c div 16)) div 16.
- R4: Attack code 0 means the envelope never rises: it stays at 0 and the stage stays at attack.
- R5: When one more rise step would reach 0xFFFF, the envelope is set to 0xFFFF. It then holds for (127−h)×HOLD_DIV ticks, where h is bits 14:8 of the `wr_ha` word.
- R6: A hold field of 127 skips the hold stage: the envelope goes from attack straight to decay.
- R7: Decay subtracts the fall step each tick. The fall step is the rise step of the decay code (bits 6:0 of the `wr_sd` word), or 1 for code 0. Decay stops at the sustain level, and that level is held. For sustain field s (bits 14:8), let a = 127−s and b = 0xFFFF >> (a div 8). The level is b − (b×(a mod 8)) div 16, or 0 when s = 0.
- R8: Release subtracts the fall step each tick. Once the value would reach or pass 0, the envelope becomes 0 and the stage becomes idle.
- R9: A `wr_sd` write with bit 15 set moves the envelope straight to release from its current value, whatever the stage.
- R10: While bit 7 of the last `wr_sd` word is set, ticks change neither `env_out` nor `stage_out`.
- R11: A `wr_sd` write with bit 15 clear restarts the envelope at 0, using the state word most recently written. A `wr_state` write by itself changes neither output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe per sample period |
| wr_state | input | 1 | Write the start/state word |
| wr_ha | input | 1 | Write the hold/attack word |
| wr_sd | input | 1 | Write the sustain/decay/phase word |
| wr_data | input | 16 | Write data shared by the three strobes |
| env_out | output | 16 | Current envelope value |
| stage_out | output | 3 | Current stage code |

## Verification
A write and a tick each take effect at the next rising edge: the stage and value registers are the only state between input and output. The bench therefore drives every strobe for exactly one cycle, starting at a falling edge, and reads the outputs at the following falling edge. A step, trigger or expiry is visible one edge after its strobe. Every duration (delay, attack to full scale, hold, decay, release) is measured as a count of single-tick strobes and compared with the count worked out from the requirement formulas.

// File: rtl/voice_env_pkg.sv
// Package: stage encoding and the computed rate and level curves shared by
// the envelope modules. Assumes 7-bit codes and a 16-bit envelope word.
package voice_env_pkg;

    localparam int ENV_W  = 16;
    localparam int CODE_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DELAY   = 3'd1,
        ST_ATTACK  = 3'd2,
        ST_HOLD    = 3'd3,
        ST_DECAY   = 3'd4,
        ST_SUSTAIN = 3'd5,
        ST_RELEASE = 3'd6
    } env_stage_t;

    // Log-spaced step: 4-bit mantissa with implied one, 3-bit exponent.
    function automatic logic [ENV_W-1:0] rise_step(input logic [CODE_W-1:0] c);
        logic [ENV_W-1:0] m;
        m = {11'd0, 1'b1, c[3:0]};
        return (c == '0) ? '0 : ENV_W'((m << c[6:4]) >> 4);
    endfunction

    // Falling step never stalls, so release always completes.
    function automatic logic [ENV_W-1:0] fall_step(input logic [CODE_W-1:0] c);
        return (c == '0) ? ENV_W'(1) : rise_step(c);
    endfunction

    // Sustain level to linear: halves every 8 codes, linear between.
    function automatic logic [ENV_W-1:0] sus_linear(input logic [CODE_W-1:0] s);
        logic [CODE_W-1:0] a;
        logic [ENV_W-1:0]  b;
        logic [19:0]       p;
        a = 7'd127 - s;
        b = 16'hFFFF >> a[6:3];
        p = {4'd0, b} * {17'd0, a[2:0]};
        return (s == '0) ? '0 : b - ENV_W'(p >> 4);
    endfunction

endpackage

// File: rtl/env_cfg_regs.sv
// Host configuration registers for one voice envelope. Holds the state word,
// the hold/attack fields and the sustain/decay fields, and turns sustain/decay
// writes into attack or release requests. Assumes at most one strobe per cycle.
module env_cfg_regs
    import voice_env_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_state,
    input  logic              wr_ha,
    input  logic              wr_sd,
    input  logic [ENV_W-1:0]  wr_data,
    output logic [ENV_W-1:0]  state_word,
    output logic [CODE_W-1:0] hold_code,
    output logic [CODE_W-1:0] atk_code,
    output logic [CODE_W-1:0] sus_code,
    output logic [CODE_W-1:0] dcy_code,
    output logic              inhibit,
    output logic              trig_atk,
    output logic              trig_rel
);

    // Capture the three host words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_word <= '0;
            hold_code  <= '0;
            atk_code   <= '0;
            sus_code   <= '0;
            dcy_code   <= '0;
            inhibit    <= 1'b0;
        end else begin
            if (wr_state) state_word <= wr_data;
            if (wr_ha) begin
                hold_code <= wr_data[14:8];
                atk_code  <= wr_data[6:0];
            end
            if (wr_sd) begin
                sus_code <= wr_data[14:8];
                inhibit  <= wr_data[7];
                dcy_code <= wr_data[6:0];
            end
        end
    end

    // Phase bit of a sustain/decay write selects the request.
    assign trig_atk = wr_sd & ~wr_data[15];
    assign trig_rel = wr_sd &  wr_data[15];

endmodule

// File: rtl/env_unit_timer.sv
// Coarse-unit countdown: a prescaler of DIV ticks per unit in front of a
// unit counter. Pulses expire on the tick that ends the last unit.
// Assumes load_val is nonzero whenever run may follow the load.
module env_unit_timer #(
    parameter int DIV   = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);

    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    // Prescale ticks into units and count units down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            cnt_q <= load_val;
        end else if (run) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expire = run && !load && (pre_q == PRE_LAST) && (cnt_q == CNT_W'(1));

    // R2/R5: the timer is never run with its unit count exhausted.
    p_count_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q != '0));

endmodule

// File: rtl/voice_env_gen.sv
// Stage sequencer and envelope accumulator for one voice. Steps once per tick
// through delay, attack, hold, decay, sustain and release. Host writes take
// priority over a tick in the same cycle; a set inhibit flag freezes ticks.
module voice_env_gen
    import voice_env_pkg::*;
#(
    parameter int DLY_DIV  = 32,
    parameter int HOLD_DIV = 4234
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_state,
    input  logic        wr_ha,
    input  logic        wr_sd,
    input  logic [15:0] wr_data,
    output logic [15:0] env_out,
    output logic [2:0]  stage_out
);

    localparam logic [ENV_W-1:0] FULL  = '1;
    localparam logic [ENV_W-1:0] D_ORG = 16'h8000;

    logic [ENV_W-1:0]  state_word;
    logic [CODE_W-1:0] hold_code, atk_code, sus_code, dcy_code;
    logic              inhibit, trig_atk, trig_rel;
    env_stage_t        stage_q;
    logic [ENV_W-1:0]  env_q;

    env_cfg_regs i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_state(wr_state), .wr_ha(wr_ha),
        .wr_sd(wr_sd), .wr_data(wr_data), .state_word(state_word),
        .hold_code(hold_code), .atk_code(atk_code), .sus_code(sus_code),
        .dcy_code(dcy_code), .inhibit(inhibit), .trig_atk(trig_atk),
        .trig_rel(trig_rel)
    );

    logic             any_wr, step_en, has_delay, atk_full, enter_hold;
    logic [ENV_W-1:0] dly_n, hold_n, a_step, f_step, sus_lvl;
    logic             dly_exp, hold_exp;

    // Derived step sizes, targets and stage-entry conditions.
    always_comb begin
        any_wr     = wr_state | wr_ha | wr_sd;
        step_en    = tick & ~any_wr & ~inhibit;
        has_delay  = ~state_word[15];
        dly_n      = D_ORG - state_word;
        hold_n     = ENV_W'(7'd127 - hold_code);
        a_step     = rise_step(atk_code);
        f_step     = fall_step(dcy_code);
        sus_lvl    = sus_linear(sus_code);
        atk_full   = ({1'b0, env_q} + {1'b0, a_step}) >= {1'b0, FULL};
        enter_hold = step_en && (stage_q == ST_ATTACK) && (a_step != '0)
                     && atk_full && (hold_n != '0);
    end

    env_unit_timer #(.DIV(DLY_DIV), .CNT_W(ENV_W)) i_dly_tmr (
        .clk(clk), .rst_n(rst_n), .load(trig_atk && has_delay),
        .load_val(dly_n), .run(step_en && stage_q == ST_DELAY),
        .expire(dly_exp)
    );

    env_unit_timer #(.DIV(HOLD_DIV), .CNT_W(ENV_W)) i_hold_tmr (
        .clk(clk), .rst_n(rst_n), .load(enter_hold), .load_val(hold_n),
        .run(step_en && stage_q == ST_HOLD), .expire(hold_exp)
    );

    // Stage sequencing and envelope arithmetic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_IDLE;
            env_q   <= '0;
        end else if (trig_rel) begin
            stage_q <= ST_RELEASE;
        end else if (trig_atk) begin
            env_q   <= '0;
            stage_q <= has_delay ? ST_DELAY : ST_ATTACK;
        end else if (step_en) begin
            case (stage_q)
                ST_DELAY: if (dly_exp) stage_q <= ST_ATTACK;
                ST_ATTACK: begin
                    if (a_step != '0) begin
                        if (atk_full) begin
                            env_q   <= FULL;
                            stage_q <= (hold_n != '0) ? ST_HOLD : ST_DECAY;
                        end else begin
                            env_q <= env_q + a_step;
                        end
                    end
                end
                ST_HOLD: if (hold_exp) stage_q <= ST_DECAY;
                ST_DECAY: begin
                    if ({1'b0, env_q} <= ({1'b0, sus_lvl} + {1'b0, f_step})) begin
                        env_q   <= sus_lvl;
                        stage_q <= ST_SUSTAIN;
                    end else begin
                        env_q <= env_q - f_step;
                    end
                end
                ST_RELEASE: begin
                    if (env_q <= f_step) begin
                        env_q   <= '0;
                        stage_q <= ST_IDLE;
                    end else begin
                        env_q <= env_q - f_step;
                    end
                end
                default: ;
            endcase
        end
    end

    assign env_out   = env_q;
    assign stage_out = stage_q;

    // R8: an idle voice is silent.
    p_idle_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_IDLE) |-> (env_q == '0));
    // R2: no output while the delay runs.
    p_delay_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_DELAY) |-> (env_q == '0));
    // R3: attack never lowers the envelope without a host write.
    p_attack_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_ATTACK && !any_wr) |=> (env_q >= $past(env_q)));
    // R8: release never raises the envelope without a host write.
    p_release_falls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_RELEASE && !any_wr) |=> (env_q <= $past(env_q)));
    // R7: sustain holds its level.
    p_sustain_flat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_SUSTAIN && !any_wr) |=> $stable(env_q));
    // R10: the freeze flag blocks all tick-driven change.
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !any_wr) |=> ($stable(env_q) && $stable(stage_q)));

endmodule

// File: tb/test_voice_env_gen.sv
module test_voice_env_gen;

    localparam int DLY  = 4;
    localparam int HOLD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_state = 1'b0, wr_ha = 1'b0, wr_sd = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] env_out;
    logic [2:0]  stage_out;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    voice_env_gen #(.DLY_DIV(DLY), .HOLD_DIV(HOLD)) i_voice_env_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_state(wr_state),
        .wr_ha(wr_ha), .wr_sd(wr_sd), .wr_data(wr_data),
        .env_out(env_out), .stage_out(stage_out)
    );

    function automatic int m_rise(int c);
        return (c == 0) ? 0 : ((16 + c % 16) * (2 ** (c / 16))) / 16;
    endfunction
    function automatic int m_fall(int c);
        return (c == 0) ? 1 : m_rise(c);
    endfunction
    function automatic int m_sus(int s);
        int a, b;
        a = 127 - s;
        b = 65535 / (2 ** (a / 8));
        return (s == 0) ? 0 : b - (b * (a % 8)) / 16;
    endfunction

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic w_state(logic [15:0] d);
        wr_state = 1'b1; wr_data = d; @(negedge clk); wr_state = 1'b0;
    endtask
    task automatic w_ha(int hold, int atk);
        wr_ha = 1'b1; wr_data = 16'((hold << 8) | atk); @(negedge clk); wr_ha = 1'b0;
    endtask
    task automatic w_sd(int ph, int sus, int inh, int dcy);
        wr_sd = 1'b1; wr_data = 16'((ph << 15) | (sus << 8) | (inh << 7) | dcy);
        @(negedge clk); wr_sd = 1'b0;
    endtask

    // Tick while the given stage persists; returns the number of ticks taken.
    task automatic run_stage(int st, output int n);
        n = 0;
        while (stage_out == 3'(st) && n < 5000) begin
            do_tick(1);
            n++;
        end
    endtask

    initial begin
        int n, e, stp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 env", env_out, 0);
        chk("R1 stage", stage_out, 0);

        // R3: exhaustive one-tick rise step for every nonzero attack code.
        w_state(16'h8000);
        for (int c = 1; c < 128; c++) begin
            w_ha(127, c);
            w_sd(0, 127, 0, 1);
            chk("R3 stage", stage_out, 2);
            do_tick(1);
            chk($sformatf("R3 code %0d", c), env_out, m_rise(c));
        end

        // R4: code 0 never rises.
        w_ha(127, 0);
        w_sd(0, 127, 0, 1);
        do_tick(20);
        chk("R4 env", env_out, 0);
        chk("R4 stage", stage_out, 2);

        // R2: delay of 3 units.
        w_state(16'h8000 - 16'd3);
        w_ha(125, 127);
        w_sd(0, 64, 0, 127);
        chk("R2 stage", stage_out, 1);
        do_tick(3 * DLY - 1);
        chk("R2 still delay", stage_out, 1);
        chk("R2 env", env_out, 0);
        do_tick(1);
        chk("R2 to attack", stage_out, 2);

        // R5: attack to full, then hold of 2 units.
        stp = m_rise(127);
        run_stage(2, n);
        chk("R5 attack ticks", n, (65535 + stp - 1) / stp);
        chk("R5 full", env_out, 65535);
        chk("R5 hold stage", stage_out, 3);
        do_tick(2 * HOLD - 1);
        chk("R5 still hold", stage_out, 3);
        do_tick(1);
        chk("R5 to decay", stage_out, 4);

        // R7: decay reaches sustain.
        run_stage(4, n);
        chk("R7 stage", stage_out, 5);
        chk("R7 level", env_out, m_sus(64));
        do_tick(10);
        chk("R7 held", env_out, m_sus(64));

        // R11: state write alone is inert; restart uses the new word.
        w_state(16'h8000 - 16'd2);
        do_tick(1);
        chk("R11 no restart", stage_out, 5);
        chk("R11 env kept", env_out, m_sus(64));
        w_sd(0, 64, 0, 127);
        chk("R11 restart env", env_out, 0);
        chk("R11 restart delay", stage_out, 1);
        do_tick(2 * DLY);
        chk("R11 delay length", stage_out, 2);

        // R9: release mid-attack from the current value.
        do_tick(10);
        chk("R9 pre", env_out, 10 * stp);
        w_sd(1, 64, 0, 100);
        chk("R9 stage", stage_out, 6);
        chk("R9 value kept", env_out, 10 * stp);
        do_tick(1);
        chk("R9 first fall", env_out, 10 * stp - m_fall(100));

        // R8: release to zero, tick count.
        e = env_out;
        run_stage(6, n);
        chk("R8 ticks", n, (e + m_fall(100) - 1) / m_fall(100));
        chk("R8 env", env_out, 0);
        chk("R8 idle", stage_out, 0);

        // R6: hold 127 skips hold.
        w_state(16'h8000);
        w_ha(127, 127);
        w_sd(0, 127, 0, 127);
        run_stage(2, n);
        chk("R6 skip hold", stage_out, 4);

        // R10: inhibit freezes release.
        w_sd(1, 127, 1, 127);
        e = env_out;
        do_tick(5);
        chk("R10 env frozen", env_out, e);
        chk("R10 stage frozen", stage_out, 6);
        w_sd(1, 127, 0, 127);
        do_tick(1);
        chk("R10 resumes", env_out, e - m_fall(127));

        // R7 sweep over sustain levels, fast decay.
        for (int s = 0; s < 128; s += 9) begin
            w_sd(0, s, 0, 127);
            run_stage(2, n);
            run_stage(4, n);
            chk($sformatf("R7 sus %0d stage", s), stage_out, 5);
            chk($sformatf("R7 sus %0d level", s), env_out, m_sus(s));
        end
        // R7 decay code 0 uses a step of one.
        w_sd(0, 127, 0, 0);
        run_stage(2, n);
        w_sd(1, 127, 0, 0);
        do_tick(3);
        chk("R7 code0 step", env_out, 65535 - 3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule